// File: doc/BRIEF.md
# In-Place Descending Exchange Sorter

This block sorts a short list of unsigned words into descending order inside a memory that it holds itself. A `start` pulse opens a load phase. During that phase the block accepts one word on each clock where `in_valid` is high and stores the words at consecutive addresses. Once the list is full, a controller runs an all-pairs exchange sort. Every position is compared with each position after it, and the two entries trade places whenever the earlier one holds the smaller value.

The memory has one read-only port and one read/write port. Both ports return their data through registers. Each comparison reads the two operands in the same cycle, one on each port, and captures them in operand registers. A swap then writes the two entries back through the write-capable port, one entry per cycle. When the sort finishes, the block drives the list out one word per clock, from the lowest address to the highest. A single-cycle `done` pulse follows the last word.

Top module: `xsort_top`

## Requirements
- R1: After `start` is seen in the idle state, the next N cycles with `in_valid` high store `in_data` at addresses 0 to N-1 in arrival order. A cycle with `in_valid` low during loading neither stores a word nor advances the address.
- R2: The unloaded words, taken in order, are the loaded list sorted into descending order (largest first). Duplicate values are kept, so the output holds the same multiset of words as the input.
- R3: The sort visits pairs (i, j) with i < j: i runs from 0 to N-2 and j from i+1 to N-1, with j restarting at i+1 each time i advances. The two entries are exchanged whenever entry i is smaller than entry j.
- R4: Each pair costs two cycles: an address cycle and a compare cycle. A swap adds two write cycles, with entry i written first and entry j written second. `out_valid` first rises exactly 2 + N(N-1) + 2S cycles after the clock edge that accepts the last loaded word, where S is the number of exchanges the R3 order performs.
- R5: `out_valid` is high for exactly N consecutive cycles per run and is low at every other time.
- R6: `done` is high for exactly one cycle, in the cycle right after the last `out_valid` word, and `out_valid` is low in that cycle.
- R7: A `start` pulse while the block is loading, sorting or unloading has no effect on the output words or on their timing.
- R8: `in_valid` outside the load phase is ignored. Words offered while idle are not stored and do not shift the load addresses of the next run.
- R9: A synchronous, active-high reset returns the controller to idle and clears its counters. After reset, `out_valid` and `done` are low. The memory contents are not cleared.
- R10: The list length `N_ITEMS` (at least 2) and the word width `DATA_W` are parameters. The block works with 12-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that opens a load phase when the block is idle |
| in_valid | input | 1 | Qualifies `in_data` during loading |
| in_data | input | DATA_W | Word to load |
| out_valid | output | 1 | Qualifies `out_data` during unloading |
| out_data | output | DATA_W | Sorted word, largest first |
| done | output | 1 | One-cycle pulse after the last output word |

## Verification
The assertions assume that `start` is a pulse and that the environment offers exactly as many valid words as the list length, so that a run always reaches the sort. The bench keeps to this. It raises `start` for a single cycle, sends exactly N valid words (some runs insert idle gaps between them), and then waits for the complete unload and the `done` pulse before it begins the next run. To test R7 and R8, the bench deliberately drives `start` and `in_valid` while the block is idle or busy. In each case the expected word order and the cycle at which `out_valid` first rises do not change.

// File: rtl/xsort_pkg.sv
package xsort_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_LOAD,
      ST_ADDR,
      ST_CMP,
      ST_WR_I,
      ST_WR_J,
      ST_UNLD,
      ST_DRAIN,
      ST_FIN
   } xsort_state_e;
endpackage

// File: rtl/xsort_dpram.sv
module xsort_dpram #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              a_re,
   input  logic [AW-1:0]     a_addr,
   output logic [DATA_W-1:0] a_q,
   input  logic              b_re,
   input  logic              b_we,
   input  logic [AW-1:0]     b_addr,
   input  logic [DATA_W-1:0] b_wd,
   output logic [DATA_W-1:0] b_q
);
   logic [DATA_W-1:0] mem [DEPTH];

   // port A: read only, registered output
   always_ff @(posedge clk) begin
      if (a_re) a_q <= mem[a_addr];
   end

   // port B: one access per cycle, write takes precedence
   always_ff @(posedge clk) begin
      if (b_we)      mem[b_addr] <= b_wd;
      else if (b_re) b_q <= mem[b_addr];
   end

   generate
      if ((1 << AW) != DEPTH) begin : g_partial_space
         // R1
         always_ff @(posedge clk) begin
            if (a_re) begin
               a_addr_range_chk: assert (int'(a_addr) < DEPTH)
                  else $error("port A address out of range");
            end
            if (b_we || b_re) begin
               b_addr_range_chk: assert (int'(b_addr) < DEPTH)
                  else $error("port B address out of range");
            end
         end
      end
   endgenerate
endmodule

// File: rtl/xsort_cmp.sv
module xsort_cmp #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] lo_pos,
   input  logic [DATA_W-1:0] hi_pos,
   output logic              exchange
);
   // R3: earlier position smaller than later position -> exchange
   assign exchange = (lo_pos < hi_pos);
endmodule

// File: rtl/xsort_ctrl.sv
module xsort_ctrl
   import xsort_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int N_ITEMS = 8,
   localparam int AW     = $clog2(N_ITEMS),
   localparam int CW     = AW + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [DATA_W-1:0] a_q,
   input  logic [DATA_W-1:0] b_q,
   input  logic              exchange,
   output logic              a_re,
   output logic [AW-1:0]     a_addr,
   output logic              b_re,
   output logic              b_we,
   output logic [AW-1:0]     b_addr,
   output logic [DATA_W-1:0] b_wd,
   output logic              out_valid,
   output logic              done
);
   localparam logic [CW-1:0] LAST_IDX = CW'(N_ITEMS - 1);
   localparam logic [CW-1:0] LAST_OUT = CW'(N_ITEMS - 2);

   xsort_state_e      state;
   logic [CW-1:0]     idx_i, idx_j, cnt;
   logic [DATA_W-1:0] op_i, op_j;
   logic              ov_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         idx_i <= '0;
         idx_j <= '0;
         cnt   <= '0;
         ov_q  <= 1'b0;
      end else begin
         ov_q <= (state == ST_UNLD);
         unique case (state)
            ST_IDLE: if (start) begin
               state <= ST_LOAD;
               cnt   <= '0;
            end
            ST_LOAD: if (in_valid) begin
               if (cnt == LAST_IDX) begin
                  state <= ST_ADDR;
                  idx_i <= '0;
                  idx_j <= CW'(1);
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_ADDR: state <= ST_CMP;
            ST_CMP, ST_WR_J: begin
               if (state == ST_CMP && exchange) begin
                  state <= ST_WR_I;
               end else if (idx_j == LAST_IDX) begin
                  if (idx_i == LAST_OUT) begin
                     state <= ST_UNLD;
                     cnt   <= '0;
                  end else begin
                     state <= ST_ADDR;
                     idx_i <= idx_i + 1'b1;
                     idx_j <= idx_i + CW'(2);
                  end
               end else begin
                  state <= ST_ADDR;
                  idx_j <= idx_j + 1'b1;
               end
            end
            ST_WR_I: state <= ST_WR_J;
            ST_UNLD: begin
               if (cnt == LAST_IDX) state <= ST_DRAIN;
               else                 cnt   <= cnt + 1'b1;
            end
            ST_DRAIN: state <= ST_FIN;
            ST_FIN:   state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   // operand registers hold the old values for both swap writes
   always_ff @(posedge clk) begin
      if (state == ST_CMP) begin
         op_i <= a_q;
         op_j <= b_q;
      end
   end

   always_comb begin
      a_re   = 1'b0;
      a_addr = idx_i[AW-1:0];
      b_re   = 1'b0;
      b_we   = 1'b0;
      b_addr = idx_j[AW-1:0];
      b_wd   = op_i;
      unique case (state)
         ST_LOAD: begin
            b_we   = in_valid;
            b_addr = cnt[AW-1:0];
            b_wd   = in_data;
         end
         ST_ADDR: begin
            a_re = 1'b1;
            b_re = 1'b1;
         end
         ST_WR_I: begin
            b_we   = 1'b1;
            b_addr = idx_i[AW-1:0];
            b_wd   = op_j;
         end
         ST_WR_J: b_we = 1'b1;
         ST_UNLD: begin
            a_re   = 1'b1;
            a_addr = cnt[AW-1:0];
         end
         default: ;
      endcase
   end

   assign out_valid = ov_q;
   assign done      = (state == ST_FIN);

   // R3
   pair_order_chk: assert property (@(posedge clk) disable iff (rst)
      (state inside {ST_ADDR, ST_CMP, ST_WR_I, ST_WR_J}) |->
         (idx_i < idx_j && idx_j <= LAST_IDX));
   // R4
   swap_seq_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_WR_J) |-> ($past(state) == ST_WR_I));
   // R4
   cmp_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_CMP) |-> ($past(state) == ST_ADDR));
   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   // R6
   done_after_word_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (!out_valid && $past(out_valid)));
   // R1
   load_write_chk: assert property (@(posedge clk) disable iff (rst)
      (b_we && !(state inside {ST_WR_I, ST_WR_J})) |-> (state == ST_LOAD && in_valid));
endmodule

// File: rtl/xsort_top.sv
module xsort_top #(
   parameter int DATA_W  = 8,
   parameter int N_ITEMS = 8,
   localparam int AW     = (N_ITEMS > 1) ? $clog2(N_ITEMS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              done
);
   generate
      if (N_ITEMS < 2) begin : g_bad_len
         $error("N_ITEMS must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic              a_re, b_re, b_we, exchange;
   logic [AW-1:0]     a_addr, b_addr;
   logic [DATA_W-1:0] a_q, b_q, b_wd;

   xsort_dpram #(.DATA_W(DATA_W), .DEPTH(N_ITEMS)) u_ram (
      .clk   (clk),
      .a_re  (a_re),
      .a_addr(a_addr),
      .a_q   (a_q),
      .b_re  (b_re),
      .b_we  (b_we),
      .b_addr(b_addr),
      .b_wd  (b_wd),
      .b_q   (b_q)
   );

   xsort_cmp #(.DATA_W(DATA_W)) u_cmp (
      .lo_pos  (a_q),
      .hi_pos  (b_q),
      .exchange(exchange)
   );

   xsort_ctrl #(.DATA_W(DATA_W), .N_ITEMS(N_ITEMS)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .in_valid (in_valid),
      .in_data  (in_data),
      .a_q      (a_q),
      .b_q      (b_q),
      .exchange (exchange),
      .a_re     (a_re),
      .a_addr   (a_addr),
      .b_re     (b_re),
      .b_we     (b_we),
      .b_addr   (b_addr),
      .b_wd     (b_wd),
      .out_valid(out_valid),
      .done     (done)
   );

   assign out_data = a_q;

   // R5
   valid_len_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(out_valid)) |-> done);
endmodule

// File: tb/xsort_top_bench.sv
`timescale 1ns/1ps
module xsort_top_bench;
   localparam int W = 12;   // R10: 12-bit words
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst, start, in_valid;
   logic [W-1:0] in_data;
   logic         out_valid, done;
   logic [W-1:0] out_data;
   int           n_checks = 0;
   int           n_errors = 0;

   always #2.5 clk = ~clk;

   xsort_top #(.DATA_W(W), .N_ITEMS(N)) u_xsort_top (
      .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
      .done(done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one full run; optional bubbles (R1), idle junk (R8), busy start (R7)
   task automatic run_list(input logic [W-1:0] vals [N], input bit bubbles,
                           input bit junk, input bit poke);
      logic [W-1:0] model [N];
      logic [W-1:0] exp_q [$];
      int swaps = 0;
      int wait_cyc = 0;
      int exp_wait;
      for (int k = 0; k < N; k++) begin
         model[k] = vals[k];
         exp_q.push_back(vals[k]);
      end
      exp_q.rsort();
      // behavioural count of exchanges in the R3 visiting order
      for (int i = 0; i < N - 1; i++)
         for (int j = i + 1; j < N; j++)
            if (model[i] < model[j]) begin
               logic [W-1:0] t = model[i];
               model[i] = model[j];
               model[j] = t;
               swaps++;
            end
      exp_wait = 2 + N * (N - 1) + 2 * swaps;

      if (junk) begin
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = W'(4095 - k);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < N; k++) begin
         if (bubbles && (k % 2 == 1)) begin
            in_valid = 1'b0;
            in_data  = W'(4095);
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_data  = vals[k];
         @(negedge clk);
      end
      in_valid = 1'b0;
      // the last word was accepted at the previous edge; count to first out word
      wait_cyc = 1;
      while (!out_valid && wait_cyc < 4 * exp_wait + 20) begin
         if (done) check(1'b0, "R6 done before unload", 1, 0);
         if (poke && wait_cyc == 3) begin
            start    = 1'b1;
            in_valid = 1'b1;
            in_data  = W'(4095);
         end else begin
            start    = 1'b0;
            in_valid = 1'b0;
         end
         @(negedge clk);
         wait_cyc++;
      end
      start    = 1'b0;
      in_valid = 1'b0;
      check(wait_cyc == exp_wait, "R4 first out_valid latency", wait_cyc, exp_wait);
      for (int k = 0; k < N; k++) begin
         check(out_valid == 1'b1, "R5 out_valid held", int'(out_valid), 1);
         check(out_data == exp_q[k], "R2 descending word", int'(out_data), int'(exp_q[k]));
         check(done == 1'b0, "R6 done during unload", int'(done), 0);
         @(negedge clk);
      end
      check(out_valid == 1'b0, "R5 out_valid after N words", int'(out_valid), 0);
      check(done == 1'b1, "R6 done after last word", int'(done), 1);
      @(negedge clk);
      check(done == 1'b0, "R6 done one cycle", int'(done), 0);
      check(out_valid == 1'b0, "R5 idle out_valid", int'(out_valid), 0);
   endtask

   initial begin
      #(5.0 * 200000);
      check(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      logic [W-1:0] v [N];
      rst      = 1'b1;
      start    = 1'b0;
      in_valid = 1'b0;
      in_data  = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R9
      check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
      check(done == 1'b0, "R9 done after reset", int'(done), 0);

      // R2 R3 R10: random 12-bit lists
      for (int r = 0; r < 4; r++) begin
         for (int k = 0; k < N; k++) v[k] = W'($urandom_range(0, 4095));
         run_list(v, 1'b0, 1'b0, 1'b0);
      end
      // R2: all equal, no exchanges
      for (int k = 0; k < N; k++) v[k] = W'(777);
      run_list(v, 1'b0, 1'b0, 1'b0);
      // R4: already descending, zero swaps
      for (int k = 0; k < N; k++) v[k] = W'(4000 - 300 * k);
      run_list(v, 1'b0, 1'b0, 1'b0);
      // R3: ascending with extremes
      for (int k = 0; k < N; k++) v[k] = (k == N - 1) ? W'(4095) : W'(k);
      run_list(v, 1'b0, 1'b0, 1'b0);
      // R1: load with gaps in in_valid, plus duplicates
      for (int k = 0; k < N; k++) v[k] = W'((k * 5) % 3 * 1000 + 1);
      run_list(v, 1'b1, 1'b0, 1'b0);
      // R8: words offered while idle; R7: start pulsed while busy
      for (int k = 0; k < N; k++) v[k] = W'($urandom_range(0, 4095));
      run_list(v, 1'b0, 1'b1, 1'b1);

      // R9: reset in mid sort returns to idle
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < N; k++) begin
         in_valid = 1'b1;
         in_data  = W'(k);
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      repeat (3 * N * N) begin
         @(negedge clk);
         if (out_valid || done) check(1'b0, "R9 output after reset", 1, 0);
      end
      check(out_valid == 1'b0, "R9 idle after mid-sort reset", int'(out_valid), 0);
      for (int k = 0; k < N; k++) v[k] = W'(N - k);
      run_list(v, 1'b0, 1'b0, 1'b0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule